// File: doc/BRIEF.md
# Scatter-Gather Descriptor DMA Engine

This block moves data between regions of memory without processor help. Software places a chain of descriptors in memory. Each descriptor names a source address, a destination address and a byte count. Software then starts the engine with the address of the first descriptor. The engine walks the chain and copies each region one 32-bit word at a time. It stops when it reaches a descriptor that carries the final-entry flag, when it finds a fault, or when the chain grows longer than a configured limit.

All memory traffic goes over a single request/acknowledge port, which can answer with an error instead of an acknowledge. Software reads the outcome from a five-bit status register, which it clears by writing ones. An interrupt line stays high while any status bit is set.

Top module: `sg_dma_engine`

## Requirements
- R1: After reset the engine is idle (`busy` = 0), `mem_req` = 0, the status register reads 0 and `irq` = 0.
- R2: Descriptor k of a chain sits at byte address base + 12*k as three words, in this order: source address, destination address, control word. In the control word, bits 17:0 are the byte count and bit 31 is the final-entry flag. Bits 30:18 have no effect.
- R3: For a valid descriptor, the engine reads count/4 words from source + 4*i and writes each one, with its bits unchanged, to destination + 4*i, in ascending i. Byte order is little-endian: the byte at the lowest address is bits 7:0.
- R4: When the last word of a descriptor with bit 31 set has been written, the engine goes idle and sets status bit 0 (read completed) and status bit 1 (write completed).
- R5: A descriptor whose byte count is zero, or is not a multiple of 256, sets status bit 4 and ends the chain. No data of that descriptor is read or written.
- R6: An error response to a data read sets status bit 2 and ends the chain at once.
- R7: An error response to a data write sets status bit 3 and ends the chain at once. The failed word is not written.
- R8: An error response while a descriptor word is being fetched sets status bit 4 and ends the chain.
- R9: If MAX_DESC descriptors finish without a final-entry flag, the engine sets status bit 4 and stops without fetching descriptor MAX_DESC.
- R10: The status register is at CSR offset 0x4, in bits 4:0. Other offsets read 0. Writing a 1 to a status bit at offset 0x4 clears that bit and leaves the other bits as they were.
- R11: `irq` is high exactly while at least one status bit is set.
- R12: A `start` pulse while `busy` is high is ignored.
- R13: Once `mem_req` is raised, it stays high with `mem_addr`, `mem_we` and `mem_wdata` held stable until `mem_ack` or `mem_err` arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a chain at `base_addr` when idle |
| base_addr | input | 32 | Byte address of the first descriptor |
| busy | output | 1 | High while a chain is being processed |
| irq | output | 1 | High while any status bit is set |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completed successfully |
| mem_err | input | 1 | Access completed with an error |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 4 | CSR byte offset |
| csr_wdata | input | 32 | CSR write data (ones clear status bits) |
| csr_rdata | output | 32 | CSR read data |

## Verification
The hardest cases to reach are faults in the middle of a chain: an error on one particular data word, or on one particular descriptor word, after earlier descriptors have already been copied. The bench memory model can be told to answer a single address and direction with an error. It aims that error at a chosen word of a chosen descriptor, then checks that everything before the fault was copied and nothing after it was. The length limit is reached by building a chain with no final-entry flag under a small MAX_DESC. Randomised response latencies make the handshake hold phases appear throughout.

// File: rtl/sg_dma_pkg.sv
package sg_dma_pkg;
  localparam int WORD_W     = 32;
  localparam int CNT_W      = 18;
  localparam int GRAN_LOG2  = 8;
  localparam int DESC_WORDS = 3;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int DESC_BYTES = DESC_WORDS * WORD_BYTES;
  localparam int FINAL_BIT  = 31;
  localparam int ST_W       = 5;
  localparam int ST_RD_DONE = 0;
  localparam int ST_WR_DONE = 1;
  localparam int ST_RD_ERR  = 2;
  localparam int ST_WR_ERR  = 3;
  localparam int ST_SG_ERR  = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_SRC, S_DST, S_CTL, S_RD, S_WR
  } eng_state_t;

  function automatic logic count_valid(input logic [CNT_W-1:0] c);
    return (c != '0) && (c[GRAN_LOG2-1:0] == '0);
  endfunction

  function automatic logic [WORD_W-1:0] desc_next(input logic [WORD_W-1:0] p);
    return p + WORD_W'(DESC_BYTES);
  endfunction

  function automatic logic [WORD_W-1:0] word_next(input logic [WORD_W-1:0] p);
    return p + WORD_W'(WORD_BYTES);
  endfunction
endpackage

// File: rtl/sg_dma_desc_check.sv
module sg_dma_desc_check
  import sg_dma_pkg::*;
(
  input  logic [WORD_W-1:0] ctl_word,
  output logic [CNT_W-1:0]  byte_cnt,
  output logic              is_final,
  output logic              cnt_ok
);
  logic unused_rsv;

  assign byte_cnt   = ctl_word[CNT_W-1:0];
  assign is_final   = ctl_word[FINAL_BIT];
  assign cnt_ok     = count_valid(ctl_word[CNT_W-1:0]);
  assign unused_rsv = &{1'b0, ctl_word[FINAL_BIT-1:CNT_W]};
endmodule

// File: rtl/sg_dma_status.sv
module sg_dma_status #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_mask,
  input  logic         clr_we,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] status
);
  logic [W-1:0] st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= (st_q & ~(clr_we ? clr_mask : '0)) | set_mask;
  end

  assign status = st_q;
endmodule

// File: rtl/sg_dma_engine.sv
module sg_dma_engine
  import sg_dma_pkg::*;
#(
  parameter int MAX_DESC = 16,
  parameter int CSR_AW   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       base_addr,
  output logic              busy,
  output logic              irq,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [31:0]       mem_rdata,
  input  logic              csr_we,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [31:0]       csr_wdata,
  output logic [31:0]       csr_rdata
);
  localparam int IDX_W = $clog2(MAX_DESC + 1);
  localparam logic [CSR_AW-1:0] STATUS_OFS = CSR_AW'(4);

  eng_state_t         state;
  logic [WORD_W-1:0]  desc_ptr, src_ptr, dst_ptr, data_q;
  logic [CNT_W-1:0]   remain;
  logic               final_q;
  logic [IDX_W-1:0]   desc_idx;

  logic [CNT_W-1:0]   ctl_cnt;
  logic               ctl_final, ctl_ok;
  logic               rsp_ok, in_fetch;
  logic               ev_fetch_err, ev_cnt_bad, ev_limit, ev_desc_err;
  logic               ev_word_done, ev_desc_done, ev_ok, ev_rd_err, ev_wr_err, ev_end;
  logic [ST_W-1:0]    st_set, st_q;
  logic               csr_hit;
  logic               unused_wd;

  sg_dma_desc_check u_chk_ctl (
    .ctl_word (mem_rdata),
    .byte_cnt (ctl_cnt),
    .is_final (ctl_final),
    .cnt_ok   (ctl_ok)
  );

  // named events, used by the FSM, the status register and the checker
  assign rsp_ok       = mem_ack && !mem_err;
  assign in_fetch     = (state == S_SRC) || (state == S_DST) || (state == S_CTL);
  assign ev_fetch_err = in_fetch && mem_err;
  assign ev_cnt_bad   = (state == S_CTL) && rsp_ok && !ctl_ok;
  assign ev_word_done = (state == S_WR) && rsp_ok;
  assign ev_desc_done = ev_word_done && (remain == CNT_W'(WORD_BYTES));
  assign ev_ok        = ev_desc_done && final_q;
  assign ev_limit     = ev_desc_done && !final_q && (desc_idx == IDX_W'(MAX_DESC - 1));
  assign ev_desc_err  = ev_fetch_err || ev_cnt_bad || ev_limit;
  assign ev_rd_err    = (state == S_RD) && mem_err;
  assign ev_wr_err    = (state == S_WR) && mem_err;
  assign ev_end       = ev_ok || ev_rd_err || ev_wr_err || ev_desc_err;

  always_comb begin
    st_set             = '0;
    st_set[ST_RD_DONE] = ev_ok;
    st_set[ST_WR_DONE] = ev_ok;
    st_set[ST_RD_ERR]  = ev_rd_err;
    st_set[ST_WR_ERR]  = ev_wr_err;
    st_set[ST_SG_ERR]  = ev_desc_err;
  end

  assign csr_hit = (csr_addr == STATUS_OFS);

  sg_dma_status #(.W(ST_W)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_mask (st_set),
    .clr_we   (csr_we && csr_hit),
    .clr_mask (csr_wdata[ST_W-1:0]),
    .status   (st_q)
  );

  assign csr_rdata = csr_hit ? {{(32-ST_W){1'b0}}, st_q} : 32'd0;
  assign irq       = |st_q;
  assign busy      = (state != S_IDLE);
  assign unused_wd = &{1'b0, csr_wdata[31:ST_W]};

  // memory port
  assign mem_req   = (state != S_IDLE);
  assign mem_we    = (state == S_WR);
  assign mem_wdata = (state == S_WR) ? data_q : '0;

  always_comb begin
    case (state)
      S_SRC:   mem_addr = desc_ptr;
      S_DST:   mem_addr = word_next(desc_ptr);
      S_CTL:   mem_addr = word_next(word_next(desc_ptr));
      S_RD:    mem_addr = src_ptr;
      S_WR:    mem_addr = dst_ptr;
      default: mem_addr = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      desc_ptr <= '0;
      src_ptr  <= '0;
      dst_ptr  <= '0;
      data_q   <= '0;
      remain   <= '0;
      final_q  <= 1'b0;
      desc_idx <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          desc_ptr <= base_addr;
          desc_idx <= '0;
          state    <= S_SRC;
        end
        S_SRC: if (mem_err) state <= S_IDLE;
               else if (mem_ack) begin
                 src_ptr <= mem_rdata;
                 state   <= S_DST;
               end
        S_DST: if (mem_err) state <= S_IDLE;
               else if (mem_ack) begin
                 dst_ptr <= mem_rdata;
                 state   <= S_CTL;
               end
        S_CTL: if (mem_err) state <= S_IDLE;
               else if (mem_ack) begin
                 if (ctl_ok) begin
                   remain  <= ctl_cnt;
                   final_q <= ctl_final;
                   state   <= S_RD;
                 end else begin
                   state <= S_IDLE;
                 end
               end
        S_RD: if (mem_err) state <= S_IDLE;
              else if (mem_ack) begin
                data_q <= mem_rdata;
                state  <= S_WR;
              end
        S_WR: if (mem_err) state <= S_IDLE;
              else if (mem_ack) begin
                src_ptr <= word_next(src_ptr);
                dst_ptr <= word_next(dst_ptr);
                remain  <= remain - CNT_W'(WORD_BYTES);
                if (!ev_desc_done) begin
                  state <= S_RD;
                end else if (final_q || ev_limit) begin
                  state <= S_IDLE;
                end else begin
                  desc_ptr <= desc_next(desc_ptr);
                  desc_idx <= desc_idx + 1'b1;
                  state    <= S_SRC;
                end
              end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

bind sg_dma_engine sg_dma_engine_chk #(.MAX_DESC(MAX_DESC), .IDX_W(IDX_W)) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .irq         (irq),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .mem_wdata   (mem_wdata),
  .mem_ack     (mem_ack),
  .mem_err     (mem_err),
  .status      (st_q),
  .ev_ok       (ev_ok),
  .ev_rd_err   (ev_rd_err),
  .ev_wr_err   (ev_wr_err),
  .ev_desc_err (ev_desc_err),
  .ev_end      (ev_end),
  .desc_idx    (desc_idx)
);

module sg_dma_engine_chk #(
  parameter int MAX_DESC = 16,
  parameter int IDX_W    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             irq,
  input logic             mem_req,
  input logic             mem_we,
  input logic [31:0]      mem_addr,
  input logic [31:0]      mem_wdata,
  input logic             mem_ack,
  input logic             mem_err,
  input logic [4:0]       status,
  input logic             ev_ok,
  input logic             ev_rd_err,
  input logic             ev_wr_err,
  input logic             ev_desc_err,
  input logic             ev_end,
  input logic [IDX_W-1:0] desc_idx
);
  a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !mem_err) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  a_r4_done_bits: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ok |=> (status[1:0] == 2'b11) && !busy);

  a_r4_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_ok, ev_rd_err, ev_wr_err, ev_desc_err}));

  a_r5_sg_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
    ev_desc_err |=> status[4] && !mem_req);

  a_r6_rd_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd_err |=> status[2] && !busy);

  a_r7_wr_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_err |=> status[3] && !busy);

  a_r9_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (desc_idx < IDX_W'(MAX_DESC)));

  a_r11_irq_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    ev_end |=> irq);
endmodule

// File: tb/sg_dma_engine_tb.sv
`timescale 1ns/1ps
module sg_dma_engine_tb;
  localparam int MAXD = 4;
  localparam logic [31:0] SENT = 32'hDEAD_BEEF;
  localparam logic [4:0] ST_OK = 5'b00011, ST_RD = 5'b00100, ST_WR = 5'b01000, ST_SG = 5'b10000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, start, busy, irq, mem_req, mem_we, mem_ack, mem_err, csr_we;
  logic [31:0] base_addr, mem_addr, mem_wdata, mem_rdata, csr_wdata, csr_rdata;
  logic [3:0]  csr_addr;

  sg_dma_engine #(.MAX_DESC(MAXD)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr), .busy(busy), .irq(irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata));

  logic [31:0] mem [0:4095];
  int vectors = 0, errs = 0;
  logic inj_on = 1'b0, inj_we = 1'b0;
  logic [31:0] inj_addr = '0;
  int lat = 0, hold_viol = 0;
  int cnt [0:7];

  // memory model with random latency, one-shot error injection, handshake monitor (R13)
  initial begin
    logic p_req, p_rsp, p_we;
    logic [31:0] p_addr, p_wd;
    p_req = 0; p_rsp = 0; p_we = 0; p_addr = 0; p_wd = 0;
    mem_ack = 0; mem_err = 0; mem_rdata = 0;
    forever begin
      @(negedge clk);
      if (p_req && !p_rsp && mem_req &&
          (mem_addr != p_addr || mem_we != p_we || mem_wdata != p_wd)) hold_viol++;
      if (mem_ack || mem_err) begin
        mem_ack = 0; mem_err = 0; lat = int'($urandom % 3);
      end else if (mem_req) begin
        if (lat > 0) lat--;
        else if (inj_on && mem_addr == inj_addr && mem_we == inj_we) mem_err = 1;
        else begin
          mem_ack = 1;
          if (mem_we) mem[mem_addr[13:2]] = mem_wdata;
          else        mem_rdata = mem[mem_addr[13:2]];
        end
      end
      p_req = mem_req; p_rsp = mem_ack || mem_err; p_we = mem_we; p_addr = mem_addr; p_wd = mem_wdata;
    end
  end

  function automatic logic [31:0] ctl_word(input int bytes, input bit fin, input logic [12:0] junk);
    return {fin, junk, 18'(bytes)};
  endfunction
  function automatic logic [31:0] src_of(input int k); return 32'h1000 + 32'(k) * 32'h200; endfunction
  function automatic logic [31:0] dst_of(input int k); return 32'h2000 + 32'(k) * 32'h200; endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin errs++; $display("FAIL %s actual=%h expected=%h", req, act, exp); end
  endtask

  task automatic init_mem();
    for (int i = 0; i < 4096; i++) mem[i] = (i < 1024) ? 32'd0 : (i < 2048) ? $urandom : SENT;
    inj_on = 0;
  endtask

  task automatic put_desc(input logic [31:0] base, input int k, input logic [31:0] s,
                          input logic [31:0] d, input logic [31:0] c);
    int w = int'(base >> 2) + 3 * k;
    mem[w] = s; mem[w+1] = d; mem[w+2] = c;
  endtask

  task automatic build(input logic [31:0] base, input int n, input bit fin_last, input bit junk);
    for (int k = 0; k < n; k++) begin
      cnt[k] = 256 * (1 + int'($urandom % 2));
      put_desc(base, k, src_of(k), dst_of(k),
               ctl_word(cnt[k], fin_last && (k == n-1), junk ? 13'($urandom) : 13'd0));
    end
  endtask

  task automatic pulse_start(input logic [31:0] b);
    @(negedge clk); start = 1; base_addr = b;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 50000) begin @(negedge clk); n++; end
  endtask

  task automatic run(input logic [31:0] b); pulse_start(b); wait_idle(); endtask

  // words [first, first+nw) of region: copied (1) or untouched (0)
  task automatic check_words(input string req, input logic [31:0] s, input logic [31:0] d,
                             input int first, input int nw, input bit copied);
    int bad = 0;
    logic [31:0] a = 0, e = 0;
    for (int i = first; i < first + nw; i++) begin
      logic [31:0] ex = copied ? mem[int'(s >> 2) + i] : SENT;
      if (mem[int'(d >> 2) + i] !== ex && bad == 0) begin a = mem[int'(d >> 2) + i]; e = ex; bad = 1; end
    end
    chk(bad == 0, req, a, e);
  endtask

  task automatic csr_clear(input logic [4:0] m);
    @(negedge clk); csr_we = 1; csr_addr = 4'h4; csr_wdata = {27'h7FFFFFF, m} & 32'h1F;
    @(negedge clk); csr_we = 0;
  endtask

  task automatic check_status(input string req, input logic [4:0] exp);
    csr_addr = 4'h4; #0.1;
    chk(csr_rdata == {27'd0, exp}, req, csr_rdata, {27'd0, exp});
    chk(irq == (exp != 0), "R11 irq level", {31'd0, irq}, {31'd0, exp != 0});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; vectors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'h0005_EED5));
    rst_n = 0; start = 0; base_addr = 0; csr_we = 0; csr_addr = 4'h4; csr_wdata = 0;
    init_mem();
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !mem_req, "R1 idle after reset", {30'd0, busy, mem_req}, 32'd0);
    check_status("R1 status after reset", 5'd0);

    // R2 R3 R4: random chains, junk in reserved control bits
    for (int t = 0; t < 4; t++) begin
      int n = 1 + int'($urandom % 3);
      init_mem(); build(32'h0 + 32'(t) * 32'h40, n, 1, 1);
      run(32'h0 + 32'(t) * 32'h40);
      for (int k = 0; k < n; k++) check_words("R3 R2 copy", src_of(k), dst_of(k), 0, cnt[k]/4, 1);
      check_words("R4 stops after final", src_of(n), dst_of(n), 0, 64, 0);
      check_status("R4 done bits", ST_OK);
      csr_clear(5'h1F);
      check_status("R10 full clear", 5'd0);
    end

    // R10: partial W1C and other offsets
    init_mem(); build(0, 1, 1, 0); run(0);
    csr_clear(5'h01); check_status("R10 clear bit0 only", 5'b00010);
    csr_addr = 4'h0; #0.1; chk(csr_rdata == 0, "R10 other offset", csr_rdata, 32'd0);
    csr_clear(5'h02); check_status("R10 clear bit1", 5'd0);

    // R5: zero count and non-multiple count
    init_mem(); build(0, 3, 1, 0); put_desc(0, 1, src_of(1), dst_of(1), ctl_word(0, 0, 0));
    run(0);
    check_words("R5 earlier copied", src_of(0), dst_of(0), 0, cnt[0]/4, 1);
    check_words("R5 zero count untouched", src_of(1), dst_of(1), 0, 64, 0);
    check_words("R5 chain ended", src_of(2), dst_of(2), 0, 64, 0);
    check_status("R5 zero count", ST_SG); csr_clear(5'h1F);
    init_mem(); build(0, 2, 1, 0); put_desc(0, 0, src_of(0), dst_of(0), ctl_word(300, 0, 0));
    run(0);
    check_words("R5 bad count untouched", src_of(0), dst_of(0), 0, 75, 0);
    check_status("R5 non-multiple", ST_SG); csr_clear(5'h1F);

    // R6: read error at word 5 of descriptor 1
    init_mem(); build(0, 2, 1, 0);
    inj_on = 1; inj_we = 0; inj_addr = src_of(1) + 32'd20; run(0); inj_on = 0;
    check_words("R6 desc0 copied", src_of(0), dst_of(0), 0, cnt[0]/4, 1);
    check_words("R6 words before fault", src_of(1), dst_of(1), 0, 5, 1);
    check_words("R6 words from fault", src_of(1), dst_of(1), 5, cnt[1]/4 - 5, 0);
    check_status("R6 read error", ST_RD); csr_clear(5'h1F);

    // R7: write error at word 3 of descriptor 0
    init_mem(); build(0, 2, 1, 0);
    inj_on = 1; inj_we = 1; inj_addr = dst_of(0) + 32'd12; run(0); inj_on = 0;
    check_words("R7 words before fault", src_of(0), dst_of(0), 0, 3, 1);
    check_words("R7 failed word unwritten", src_of(0), dst_of(0), 3, cnt[0]/4 - 3, 0);
    check_words("R7 next desc untouched", src_of(1), dst_of(1), 0, cnt[1]/4, 0);
    check_status("R7 write error", ST_WR); csr_clear(5'h1F);

    // R8: error on destination word fetch of descriptor 1
    init_mem(); build(32'h100, 2, 1, 0);
    inj_on = 1; inj_we = 0; inj_addr = 32'h100 + 32'd16; run(32'h100); inj_on = 0;
    check_words("R8 desc0 copied", src_of(0), dst_of(0), 0, cnt[0]/4, 1);
    check_words("R8 desc1 untouched", src_of(1), dst_of(1), 0, cnt[1]/4, 0);
    check_status("R8 fetch error", ST_SG); csr_clear(5'h1F);

    // R9: chain longer than MAXD with no final flag
    init_mem(); build(0, MAXD + 1, 0, 1); run(0);
    for (int k = 0; k < MAXD; k++) check_words("R9 within limit copied", src_of(k), dst_of(k), 0, cnt[k]/4, 1);
    check_words("R9 beyond limit untouched", src_of(MAXD), dst_of(MAXD), 0, cnt[MAXD]/4, 0);
    check_status("R9 limit", ST_SG); csr_clear(5'h1F);

    // R12: start while busy is ignored
    init_mem(); build(0, 2, 1, 0);
    put_desc(32'h800, 0, src_of(0), 32'h3800, ctl_word(256, 1, 0));
    pulse_start(0);
    repeat (10) @(negedge clk);
    chk(busy == 1, "R12 busy mid chain", {31'd0, busy}, 32'd1);
    start = 1; base_addr = 32'h800; @(negedge clk); start = 0;
    wait_idle();
    check_words("R12 first chain copied", src_of(1), dst_of(1), 0, cnt[1]/4, 1);
    check_words("R12 second start ignored", src_of(0), 32'h3800, 0, 64, 0);
    check_status("R12 status", ST_OK); csr_clear(5'h1F);

    chk(hold_viol == 0, "R13 request hold", 32'(hold_viol), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule